// File: doc/BRIEF.md
# Multi-Bank Busy Status Responder

This block models the read side of a four-bank flash array while its embedded program and erase operations run. One bank at a time may run an operation. A simplified timer stands in for the real program and erase durations. A read addressed to the busy bank returns a status word instead of array contents. The status word carries a polling bit and a bit that toggles on every status read. Reads to the other banks return stored data in the same cycles, so software can keep running out of one bank while it polls another.

An erase can be suspended. The bank then becomes readable again, except for the sector under erase, which reports a suspended-status word. Another sector may be programmed while the erase is parked, and the erase resumes later for exactly its remaining cycles. An abort request models the hardware reset pin: it cancels any running or parked operation and holds the block not-ready for a short or a long recovery time. A small behavioural storage stub gives the commits an observable effect. That stub holds one word per address, starts out erased (all ones), and programming can only clear bits.

Top module: `mbank_busy_resp`

## Requirements
- R1: At most one operation runs at a time. `busy_vld` is high and `busy_bank` names its bank while it runs. An operation start arriving while one runs is ignored and leaves the storage unchanged.
- R2: An accepted program holds `ready` low for exactly PROG_CYC cycles and then stores old AND new data at its word. An accepted erase holds `ready` low for ERASE_CYC running cycles and then sets every word of its sector to 16'hFFFF. A sector is the top SECT_W bits of the word address.
- R3: While an operation runs, a read of any address in its bank returns a status word. Bits 15:8 are zero. Bit 7 is the inverse of bit 7 of the program data, or 0 for an erase. Bit 3 is 1 for an erase and 0 for a program. Bits 5:4 and 2:0 are zero.
- R4: Bit 6 of the status word inverts on each successive status read of a running operation. Once the operation completes, reads of the bank return stored data, and two consecutive reads agree.
- R5: Every read request is answered one cycle later with `rd_ack` high. Reads of banks that are not busy return stored data even while another bank is busy.
- R6: A suspend request naming the bank of a running erase parks the erase. From the next cycle `ready` is high, `busy_vld` is low, and the other sectors of that bank read as stored data. A suspend request naming another bank, or arriving during a program, is ignored.
- R7: A read of the parked sector returns a status word with bit 7 = 1 and bit 3 = 0. Bit 6 is held at its last value. Bit 2 inverts on each such read.
- R8: While an erase is parked, a program to any other sector is accepted and runs normally. A program to the parked sector and any erase start are rejected.
- R9: A resume request naming the parked bank restarts the erase, and the erase then runs for its remaining cycles, so its running time totals ERASE_CYC. A resume request is ignored while a program runs.
- R10: An abort request cancels running and parked operations without touching storage. It holds `ready` low for REC_BUSY_CYC cycles if an operation was running or parked, and for REC_IDLE_CYC cycles otherwise. Starts, suspends and resumes are ignored during that time.
- R11: After `rst_n` is released, `ready` is high, `busy_vld` and `rd_ack` are low, and every word reads 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_start | input | 1 | Operation start request |
| op_erase | input | 1 | 1 = sector erase, 0 = word program |
| op_bank | input | BANK_W | Bank of the operation |
| op_addr | input | WORD_W | Word address in the bank (upper SECT_W bits select the sector) |
| op_data | input | 16 | Program data |
| rd_req | input | 1 | Read strobe |
| rd_bank | input | BANK_W | Read bank |
| rd_addr | input | WORD_W | Read word address |
| rd_ack | output | 1 | Read answer valid, one cycle after the strobe |
| rd_data | output | 16 | Status word or stored data |
| susp_req | input | 1 | Erase suspend request |
| susp_bank | input | BANK_W | Bank named by the suspend request |
| res_req | input | 1 | Erase resume request |
| res_bank | input | BANK_W | Bank named by the resume request |
| abort_req | input | 1 | Reset-pin style abort |
| ready | output | 1 | High when no operation runs and no recovery is pending |
| busy_vld | output | 1 | An operation is running |
| busy_bank | output | BANK_W | Bank of the running operation |

## Verification
Each read answer is due one cycle after the strobe. The bench drives the strobe at a falling edge and samples `rd_data` at the next falling edge. Operation, recovery and suspended-erase durations are measured with a free-running cycle count. The count is taken at the falling edge after the accepting edge and again at the first falling edge where `ready` is high, so the difference equals the programmed cycle count exactly. Requests that should be ignored are checked at the following falling edge, through `ready` and `busy_vld`, and later through stored data read back over the read port.

// File: rtl/mbr_pkg.sv
package mbr_pkg;
  parameter int DATA_W = 16;

  localparam int POLL_BIT = 7;
  localparam int TOG_BIT  = 6;
  localparam int ERS_BIT  = 3;
  localparam int ALT_BIT  = 2;

  function automatic logic [DATA_W-1:0] mk_status(input logic poll, input logic tog,
                                                  input logic ers, input logic alt);
    logic [DATA_W-1:0] w;
    w = '0;
    w[POLL_BIT] = poll;
    w[TOG_BIT]  = tog;
    w[ERS_BIT]  = ers;
    w[ALT_BIT]  = alt;
    return w;
  endfunction

  function automatic logic [DATA_W-1:0] pgm_merge(input logic [DATA_W-1:0] old_w,
                                                  input logic [DATA_W-1:0] new_w);
    return old_w & new_w;
  endfunction
endpackage

// File: rtl/mbr_op_ctrl.sv
module mbr_op_ctrl import mbr_pkg::*; #(
  parameter int NBANK        = 4,
  parameter int WORD_W       = 4,
  parameter int SECT_W       = 2,
  parameter int PROG_CYC     = 6,
  parameter int ERASE_CYC    = 20,
  parameter int REC_BUSY_CYC = 8,
  parameter int REC_IDLE_CYC = 2,
  localparam int BANK_W      = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic              start_erase,
  input  logic [BANK_W-1:0] start_bank,
  input  logic [WORD_W-1:0] start_addr,
  input  logic [DATA_W-1:0] start_data,
  input  logic              susp_req,
  input  logic [BANK_W-1:0] susp_bank,
  input  logic              res_req,
  input  logic [BANK_W-1:0] res_bank,
  input  logic              abort_req,
  output logic              act_vld,
  output logic              act_erase,
  output logic [BANK_W-1:0] act_bank,
  output logic [WORD_W-1:0] act_addr,
  output logic [DATA_W-1:0] act_data,
  output logic              sus_vld,
  output logic [BANK_W-1:0] sus_bank,
  output logic [SECT_W-1:0] sus_sect,
  output logic              done_pgm,
  output logic              done_ers,
  output logic              ready
);
  localparam int MAX_OP  = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int MAX_REC = (REC_BUSY_CYC > REC_IDLE_CYC) ? REC_BUSY_CYC : REC_IDLE_CYC;
  localparam int MAX_C   = (MAX_OP > MAX_REC) ? MAX_OP : MAX_REC;
  localparam int CNT_W   = $clog2(MAX_C + 1);
  localparam int OFF_W   = WORD_W - SECT_W;

  logic [CNT_W-1:0]  act_cnt, sus_cnt, rec_cnt;
  logic [SECT_W-1:0] start_sect;
  logic recovering, hits_susp, start_ok, done_ev, susp_ok, res_ok;

  assign start_sect = start_addr[WORD_W-1 -: SECT_W];
  assign recovering = (rec_cnt != '0);
  assign hits_susp  = sus_vld && (start_bank == sus_bank) && (start_sect == sus_sect);
  assign start_ok   = start_req && !abort_req && !act_vld && !recovering &&
                      !(sus_vld && (start_erase || hits_susp));
  assign done_ev    = act_vld && !abort_req && (act_cnt == CNT_W'(1));
  assign susp_ok    = susp_req && act_vld && act_erase && (act_bank == susp_bank) &&
                      !abort_req && !done_ev;
  assign res_ok     = res_req && sus_vld && !act_vld && !recovering && !abort_req &&
                      (res_bank == sus_bank);
  assign done_pgm   = done_ev && !act_erase;
  assign done_ers   = done_ev && act_erase;
  assign ready      = !act_vld && !recovering;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_vld   <= 1'b0;
      act_erase <= 1'b0;
      act_bank  <= '0;
      act_addr  <= '0;
      act_data  <= '0;
      act_cnt   <= '0;
      sus_vld   <= 1'b0;
      sus_bank  <= '0;
      sus_sect  <= '0;
      sus_cnt   <= '0;
      rec_cnt   <= '0;
    end else if (abort_req) begin
      act_vld <= 1'b0;
      sus_vld <= 1'b0;
      rec_cnt <= (act_vld || sus_vld) ? CNT_W'(REC_BUSY_CYC) : CNT_W'(REC_IDLE_CYC);
    end else begin
      if (recovering) rec_cnt <= rec_cnt - CNT_W'(1);
      if (act_vld) begin
        if (done_ev) begin
          act_vld <= 1'b0;
        end else if (susp_ok) begin
          act_vld  <= 1'b0;
          sus_vld  <= 1'b1;
          sus_bank <= act_bank;
          sus_sect <= act_addr[WORD_W-1 -: SECT_W];
          sus_cnt  <= act_cnt - CNT_W'(1);
        end else begin
          act_cnt <= act_cnt - CNT_W'(1);
        end
      end else if (res_ok) begin
        act_vld   <= 1'b1;
        act_erase <= 1'b1;
        act_bank  <= sus_bank;
        act_addr  <= WORD_W'(sus_sect) << OFF_W;
        act_cnt   <= sus_cnt;
        sus_vld   <= 1'b0;
      end else if (start_ok) begin
        act_vld   <= 1'b1;
        act_erase <= start_erase;
        act_bank  <= start_bank;
        act_addr  <= start_addr;
        act_data  <= start_data;
        act_cnt   <= start_erase ? CNT_W'(ERASE_CYC) : CNT_W'(PROG_CYC);
      end
    end
  end

  p_one_bank_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (act_vld && !done_ev && !susp_ok && !abort_req) |=> (act_vld && $stable(act_bank)));

  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> !ready);

  p_cnt_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    act_vld |-> (act_cnt != '0));

  p_susp_frees_r6: assert property (@(posedge clk) disable iff (!rst_n)
    susp_ok |=> (ready && sus_vld));

  p_reject_susp_sect_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && !start_erase && hits_susp && !act_vld && !recovering &&
     !abort_req && !res_ok) |=> !act_vld);

  p_abort_recover_r10: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |=> (!ready && !sus_vld && !act_vld));
endmodule

// File: rtl/mbr_array.sv
module mbr_array import mbr_pkg::*; #(
  parameter int NBANK   = 4,
  parameter int WORD_W  = 4,
  parameter int SECT_W  = 2,
  localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_pgm,
  input  logic              wr_ers,
  input  logic [BANK_W-1:0] wr_bank,
  input  logic [WORD_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [BANK_W-1:0] rd_bank,
  input  logic [WORD_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_word
);
  localparam int WPB   = 1 << WORD_W;
  localparam int NWORD = NBANK * WPB;
  localparam int OFF_W = WORD_W - SECT_W;

  logic [DATA_W-1:0] words [NWORD];
  logic [SECT_W-1:0] wr_sect;

  assign wr_sect = wr_addr[WORD_W-1 -: SECT_W];

  for (genvar g = 0; g < NWORD; g++) begin : g_word
    localparam int B = g / WPB;
    localparam int W = g % WPB;
    logic [DATA_W-1:0] word_q;
    logic hit_pgm, hit_ers;

    assign hit_pgm = wr_pgm && (wr_bank == BANK_W'(B)) && (wr_addr == WORD_W'(W));
    assign hit_ers = wr_ers && (wr_bank == BANK_W'(B)) && (wr_sect == SECT_W'(W >> OFF_W));

    always_ff @(posedge clk) begin
      if (!rst_n)       word_q <= '1;
      else if (hit_pgm) word_q <= pgm_merge(word_q, wr_data);
      else if (hit_ers) word_q <= '1;
    end
    assign words[g] = word_q;
  end

  assign rd_word = words[{rd_bank, rd_addr}];
endmodule

// File: rtl/mbr_read_mux.sv
module mbr_read_mux import mbr_pkg::*; #(
  parameter int NBANK   = 4,
  parameter int WORD_W  = 4,
  parameter int SECT_W  = 2,
  localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic [BANK_W-1:0] rd_bank,
  input  logic [WORD_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] arr_word,
  input  logic              act_vld,
  input  logic              act_erase,
  input  logic [BANK_W-1:0] act_bank,
  input  logic              act_pd7,
  input  logic              sus_vld,
  input  logic [BANK_W-1:0] sus_bank,
  input  logic [SECT_W-1:0] sus_sect,
  output logic              rd_ack,
  output logic [DATA_W-1:0] rd_data
);
  logic stat_act, stat_sus, tog6_q, tog2_q, poll;
  logic st_act_q, st_sus_q;

  assign stat_act = rd_req && act_vld && (rd_bank == act_bank);
  assign stat_sus = rd_req && !stat_act && sus_vld && (rd_bank == sus_bank) &&
                    (rd_addr[WORD_W-1 -: SECT_W] == sus_sect);
  assign poll     = act_erase ? 1'b0 : !act_pd7;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ack   <= 1'b0;
      rd_data  <= '0;
      tog6_q   <= 1'b0;
      tog2_q   <= 1'b0;
      st_act_q <= 1'b0;
      st_sus_q <= 1'b0;
    end else begin
      rd_ack   <= rd_req;
      st_act_q <= stat_act;
      st_sus_q <= stat_sus;
      if (stat_act) begin
        rd_data <= mk_status(poll, tog6_q, act_erase, 1'b0);
        tog6_q  <= !tog6_q;
      end else if (stat_sus) begin
        rd_data <= mk_status(1'b1, tog6_q, 1'b0, tog2_q);
        tog2_q  <= !tog2_q;
      end else if (rd_req) begin
        rd_data <= arr_word;
      end
    end
  end

  p_ack_next_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_ack);

  p_toggle_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_act_q && $past(st_act_q)) |-> (rd_data[TOG_BIT] != $past(rd_data[TOG_BIT])));

  p_susp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_sus_q && $past(st_sus_q)) |->
      ($stable(rd_data[TOG_BIT]) && (rd_data[ALT_BIT] != $past(rd_data[ALT_BIT]))));
endmodule

// File: rtl/mbank_busy_resp.sv
module mbank_busy_resp import mbr_pkg::*; #(
  parameter int NBANK        = 4,
  parameter int WORD_W       = 4,
  parameter int SECT_W       = 2,
  parameter int PROG_CYC     = 6,
  parameter int ERASE_CYC    = 20,
  parameter int REC_BUSY_CYC = 8,
  parameter int REC_IDLE_CYC = 2,
  localparam int BANK_W      = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_start,
  input  logic              op_erase,
  input  logic [BANK_W-1:0] op_bank,
  input  logic [WORD_W-1:0] op_addr,
  input  logic [DATA_W-1:0] op_data,
  input  logic              rd_req,
  input  logic [BANK_W-1:0] rd_bank,
  input  logic [WORD_W-1:0] rd_addr,
  output logic              rd_ack,
  output logic [DATA_W-1:0] rd_data,
  input  logic              susp_req,
  input  logic [BANK_W-1:0] susp_bank,
  input  logic              res_req,
  input  logic [BANK_W-1:0] res_bank,
  input  logic              abort_req,
  output logic              ready,
  output logic              busy_vld,
  output logic [BANK_W-1:0] busy_bank
);
  logic              act_vld, act_erase, sus_vld, done_pgm, done_ers;
  logic [BANK_W-1:0] act_bank, sus_bank;
  logic [WORD_W-1:0] act_addr;
  logic [DATA_W-1:0] act_data, arr_word;
  logic [SECT_W-1:0] sus_sect;

  mbr_op_ctrl #(
    .NBANK(NBANK), .WORD_W(WORD_W), .SECT_W(SECT_W), .PROG_CYC(PROG_CYC),
    .ERASE_CYC(ERASE_CYC), .REC_BUSY_CYC(REC_BUSY_CYC), .REC_IDLE_CYC(REC_IDLE_CYC)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .start_req(op_start), .start_erase(op_erase), .start_bank(op_bank),
    .start_addr(op_addr), .start_data(op_data),
    .susp_req(susp_req), .susp_bank(susp_bank),
    .res_req(res_req), .res_bank(res_bank), .abort_req(abort_req),
    .act_vld(act_vld), .act_erase(act_erase), .act_bank(act_bank),
    .act_addr(act_addr), .act_data(act_data),
    .sus_vld(sus_vld), .sus_bank(sus_bank), .sus_sect(sus_sect),
    .done_pgm(done_pgm), .done_ers(done_ers), .ready(ready)
  );

  mbr_array #(.NBANK(NBANK), .WORD_W(WORD_W), .SECT_W(SECT_W)) u_array (
    .clk(clk), .rst_n(rst_n),
    .wr_pgm(done_pgm), .wr_ers(done_ers), .wr_bank(act_bank),
    .wr_addr(act_addr), .wr_data(act_data),
    .rd_bank(rd_bank), .rd_addr(rd_addr), .rd_word(arr_word)
  );

  mbr_read_mux #(.NBANK(NBANK), .WORD_W(WORD_W), .SECT_W(SECT_W)) u_rmux (
    .clk(clk), .rst_n(rst_n),
    .rd_req(rd_req), .rd_bank(rd_bank), .rd_addr(rd_addr), .arr_word(arr_word),
    .act_vld(act_vld), .act_erase(act_erase), .act_bank(act_bank),
    .act_pd7(act_data[POLL_BIT]),
    .sus_vld(sus_vld), .sus_bank(sus_bank), .sus_sect(sus_sect),
    .rd_ack(rd_ack), .rd_data(rd_data)
  );

  assign busy_vld  = act_vld;
  assign busy_bank = act_bank;
endmodule

// File: tb/mbank_busy_resp_bench.sv
module mbank_busy_resp_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4, WW = 4, SW = 2;
  localparam int PC = 6, EC = 20, RB = 8, RI = 2;
  localparam int WPB = 1 << WW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic op_start = 0, op_erase = 0, rd_req = 0, susp_req = 0, res_req = 0, abort_req = 0;
  logic [1:0] op_bank = 0, rd_bank = 0, susp_bank = 0, res_bank = 0;
  logic [WW-1:0] op_addr = 0, rd_addr = 0;
  logic [15:0] op_data = 0;
  logic rd_ack, ready, busy_vld;
  logic [15:0] rd_data;
  logic [1:0] busy_bank;

  mbank_busy_resp #(.NBANK(NB), .WORD_W(WW), .SECT_W(SW), .PROG_CYC(PC),
    .ERASE_CYC(EC), .REC_BUSY_CYC(RB), .REC_IDLE_CYC(RI)) u_mbank_busy_resp (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_erase(op_erase),
    .op_bank(op_bank), .op_addr(op_addr), .op_data(op_data),
    .rd_req(rd_req), .rd_bank(rd_bank), .rd_addr(rd_addr),
    .rd_ack(rd_ack), .rd_data(rd_data),
    .susp_req(susp_req), .susp_bank(susp_bank), .res_req(res_req), .res_bank(res_bank),
    .abort_req(abort_req), .ready(ready), .busy_vld(busy_vld), .busy_bank(busy_bank));

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  logic [15:0] model [NB*WPB];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finish");
    finish_run();
  end

  task automatic rd(input int b, input int a, output logic [15:0] d);
    rd_req = 1; rd_bank = 2'(b); rd_addr = WW'(a);
    @(negedge clk);
    rd_req = 0;
    d = rd_data;
    chk(rd_ack === 1'b1, "R5 rd_ack", rd_ack, 1);
  endtask

  task automatic start(input bit er, input int b, input int a, input logic [15:0] d);
    op_start = 1; op_erase = er; op_bank = 2'(b); op_addr = WW'(a); op_data = d;
    @(negedge clk);
    op_start = 0;
  endtask

  task automatic wait_ready();
    int guard = 0;
    while (!ready && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  function automatic logic [15:0] pat(input int b, input int w);
    return 16'((b * 16 + w) * 1031) ^ 16'h5A3C;
  endfunction

  initial begin
    logic [15:0] s1, s2, x1, x2, pd;
    int t0, ts, tr, el1, ta;
    for (int i = 0; i < NB*WPB; i++) model[i] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R11 reset state
    chk(ready === 1'b1, "R11 ready after reset", ready, 1);
    chk(busy_vld === 1'b0, "R11 busy_vld after reset", busy_vld, 0);
    chk(rd_ack === 1'b0, "R11 rd_ack after reset", rd_ack, 0);
    for (int b = 0; b < NB; b++)
      for (int w = 0; w < WPB; w++) begin
        rd(b, w, x1);
        chk(x1 === 16'hFFFF, "R11 erased after reset", x1, 16'hFFFF);
      end

    // Program sweep over every word
    for (int b = 0; b < NB; b++)
      for (int w = 0; w < WPB; w++) begin
        pd = pat(b, w);
        start(0, b, w, pd);
        t0 = cyc;
        chk(busy_vld === 1'b1 && busy_bank === 2'(b), "R1 busy bank", busy_bank, b);
        chk(ready === 1'b0, "R2 ready low", ready, 0);
        rd(b, w, s1);
        rd(b, (w + 5) % WPB, s2);
        chk((s1 & 16'hFFBF) === (16'(!pd[7]) << 7), "R3 program status", s1, 16'(!pd[7]) << 7);
        chk((s2 & 16'hFFBF) === (16'(!pd[7]) << 7), "R3 program status 2", s2, 16'(!pd[7]) << 7);
        chk(s1[6] !== s2[6], "R4 toggle flips", s2[6], !s1[6]);
        rd((b + 1) % NB, w, x1);
        chk(x1 === model[((b + 1) % NB) * WPB + w], "R5 other bank data", x1,
            model[((b + 1) % NB) * WPB + w]);
        start(0, (b + 2) % NB, w, 16'h0000);   // R1: must be ignored
        wait_ready();
        chk(cyc - t0 == PC, "R2 program duration", cyc - t0, PC);
        model[b * WPB + w] = model[b * WPB + w] & pd;
        rd(b, w, x1);
        rd(b, w, x2);
        chk(x1 === model[b * WPB + w], "R2 programmed value", x1, model[b * WPB + w]);
        chk(x2 === x1, "R4 stable after done", x2, x1);
      end

    // R2 program only clears bits
    start(0, 0, 0, 16'h0FF0);
    wait_ready();
    model[0] = model[0] & 16'h0FF0;
    rd(0, 0, x1);
    chk(x1 === model[0], "R2 and-merge", x1, model[0]);

    // Erase of bank 2 sector 1 with suspend
    start(1, 2, 4, 16'h0);
    t0 = cyc;
    rd(2, 9, s1);
    chk((s1 & 16'hFFBF) === 16'h0008, "R3 erase status", s1, 16'h0008);
    susp_req = 1; susp_bank = 1;
    @(negedge clk);
    susp_req = 0;
    chk(ready === 1'b0, "R6 wrong-bank suspend ignored", ready, 0);
    susp_req = 1; susp_bank = 2;
    @(negedge clk);
    susp_req = 0;
    ts = cyc;
    el1 = ts - t0;
    chk(ready === 1'b1 && busy_vld === 1'b0, "R6 suspend frees", {ready, busy_vld}, 2'b10);
    rd(2, 0, x1);
    chk(x1 === model[2 * WPB + 0], "R6 other sector readable", x1, model[2 * WPB]);
    rd(2, 5, s1);
    rd(2, 6, s2);
    chk((s1 & 16'hFFBB) === 16'h0080, "R7 suspended status", s1, 16'h0080);
    chk(s2[6] === s1[6], "R7 bit6 held", s2[6], s1[6]);
    chk(s2[2] !== s1[2], "R7 bit2 toggles", s2[2], !s1[2]);
    start(1, 0, 0, 16'h0);
    chk(ready === 1'b1, "R8 erase start rejected", ready, 1);
    start(0, 2, 5, 16'h0);
    chk(ready === 1'b1 && busy_vld === 1'b0, "R8 suspended-sector program rejected", ready, 1);
    pd = 16'h3C3C;
    start(0, 2, 1, pd);
    t0 = cyc;
    chk(ready === 1'b0 && busy_bank === 2'd2, "R8 other-sector program runs", ready, 0);
    res_req = 1; res_bank = 2;
    @(negedge clk);
    res_req = 0;
    wait_ready();
    chk(cyc - t0 == PC, "R8 program in suspend duration", cyc - t0, PC);
    model[2 * WPB + 1] = model[2 * WPB + 1] & pd;
    rd(2, 5, s1);
    chk(s1[7] === 1'b1 && s1[3] === 1'b0, "R9 resume ignored during program", s1, 16'h0080);
    rd(2, 1, x1);
    chk(x1 === model[2 * WPB + 1], "R8 program in suspend value", x1, model[2 * WPB + 1]);
    res_req = 1; res_bank = 2;
    @(negedge clk);
    res_req = 0;
    tr = cyc;
    chk(ready === 1'b0 && busy_vld === 1'b1, "R9 resume restarts", ready, 0);
    wait_ready();
    chk(el1 + (cyc - tr) == EC, "R9 erase total duration", el1 + (cyc - tr), EC);
    for (int w = 4; w < 8; w++) begin
      model[2 * WPB + w] = 16'hFFFF;
      rd(2, w, x1);
      chk(x1 === 16'hFFFF, "R2 erased sector", x1, 16'hFFFF);
    end

    // R10 abort while idle
    abort_req = 1;
    @(negedge clk);
    abort_req = 0;
    ta = cyc;
    wait_ready();
    chk(cyc - ta == RI, "R10 idle recovery", cyc - ta, RI);

    // R10 abort while busy, start during recovery ignored
    start(0, 1, 3, 16'h1234);
    @(negedge clk);
    @(negedge clk);
    abort_req = 1;
    @(negedge clk);
    abort_req = 0;
    ta = cyc;
    chk(busy_vld === 1'b0, "R10 abort cancels", busy_vld, 0);
    start(0, 3, 3, 16'h0000);
    wait_ready();
    chk(cyc - ta == RB, "R10 busy recovery", cyc - ta, RB);
    chk(busy_vld === 1'b0, "R10 start in recovery ignored", busy_vld, 0);
    rd(1, 3, x1);
    chk(x1 === model[1 * WPB + 3], "R10 storage untouched", x1, model[1 * WPB + 3]);

    // R10 abort of a parked erase
    start(1, 3, 8, 16'h0);
    @(negedge clk);
    susp_req = 1; susp_bank = 3;
    @(negedge clk);
    susp_req = 0;
    abort_req = 1;
    @(negedge clk);
    abort_req = 0;
    ta = cyc;
    wait_ready();
    chk(cyc - ta == RB, "R10 parked recovery", cyc - ta, RB);
    res_req = 1; res_bank = 3;
    @(negedge clk);
    res_req = 0;
    chk(ready === 1'b1, "R10 nothing left to resume", ready, 1);
    rd(3, 8, x1);
    chk(x1 === model[3 * WPB + 8], "R10 parked erase cancelled", x1, model[3 * WPB + 8]);

    // R1 final readback: ignored starts left storage intact
    for (int b = 0; b < NB; b++)
      for (int w = 0; w < WPB; w++) begin
        rd(b, w, x1);
        chk(x1 === model[b * WPB + w], "R1 final storage", x1, model[b * WPB + w]);
      end

    finish_run();
  end
endmodule